// File: doc/BRIEF.md
# Flash Write-Command Sequencer

This block is the command state machine of a NOR-style flash device. It holds a small behavioural storage array. It watches single-cycle bus writes made of an address, a data byte and a write strobe. It recognises the multi-write unlock protocol and launches a timed embedded program for each complete program request. While that program runs, it holds a ready line low. Reads are registered. They return array contents in normal operation, status bits while a program runs, and the contents of a small secured region while that overlay is switched on.

Besides the standard four-write program, the sequencer supports a bypass mode in which each program needs only two writes. An accelerate input drops the sequencer straight into bypass mode. A hardware reset cancels a running program before it changes the array. Programming can only clear bits, and a status bit reports any request that tries to raise a cleared bit.

The states are:
- IDLE (normal read)
- UNLK1 (first unlock seen)
- UNLK2 (both unlocks seen)
- PDATA (waiting for target address and data)
- BUSY (embedded program running)
- BYP (bypass idle)
- BDATA (bypass waiting for address and data)
- BRST (bypass reset, first write seen)
- SEXIT (secured exit, waiting for the final write)

The transitions are:
- IDLE→UNLK1 on AAh@555h.
- UNLK1→UNLK2 on 55h@2AAh.
- UNLK2→PDATA on A0h@555h.
- UNLK2→BYP on 20h@555h.
- UNLK2→IDLE with the overlay on, on 88h@555h.
- UNLK2→SEXIT on 90h@555h while the overlay is on.
- PDATA→BUSY and BDATA→BUSY on any write.
- BUSY→IDLE or BUSY→BYP when the timer expires.
- BYP→BDATA on A0h.
- BYP→BRST on 90h.
- BRST→IDLE on 00h, otherwise BRST→BYP.
- SEXIT→IDLE on any write, with the overlay cleared only by 00h.
- Any unexpected write in UNLK1 or UNLK2 leads to IDLE.
- Accelerate leads to BYP from IDLE, UNLK1, UNLK2 or PDATA.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes AAh@555h, 55h@2AAh, A0h@555h, then data D at any address A, start a program. Ready falls in the cycle after the last write. Afterwards a read of A returns the old value AND D.
- R2: Ready stays low for exactly PROG_CYCLES cycles. Every write made while ready is low is ignored and leaves no partial sequence behind.
- R3: A read while ready is low returns status rather than data. Bit 7 is the complement of bit 7 of the data being programmed. Bit 6 inverts on every such read. Bit 5 is 1 exactly when the data has a 1 where the stored word has a 0. All other bits are 0.
- R4: Programming only clears bits. A request to set a cleared bit leaves that bit at 0.
- R5: The writes AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. In bypass mode, A0h at any address followed by A and D programs A. This repeats without unlock writes.
- R6: In bypass mode, a write other than A0h or 90h is ignored. Bypass mode continues and the array is unchanged.
- R7: In bypass mode, 90h then 00h returns the sequencer to normal mode. After that, a lone A0h followed by data does not program.
- R8: A write that breaks an expected sequence returns the sequencer to normal mode without a program. In normal mode, F0h is accepted and has no effect.
- R9: A high accelerate input while not busy, not in bypass and not secured puts the sequencer into bypass mode on the next cycle.
- R10: The writes AAh@555h, 55h@2AAh, 88h@555h switch reads and programs to a 2^SAW-word secured region indexed by the low SAW address bits. The writes AAh@555h, 55h@2AAh, 90h@555h, 00h switch them back to the main array.
- R11: While the secured overlay is on, neither the 20h bypass command nor the accelerate input enters bypass mode. Bypass and overlay are never on together.
- R12: A low rst_n cancels a running program at once. Ready goes high, the target word keeps its old value, and both bypass mode and the overlay are cleared.
- R13: rdata is registered. It is loaded only on a cycle with rd high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we | input | 1 | Write strobe, one bus write per high cycle |
| addr | input | AW | Word address for writes and reads |
| wdata | input | DW | Write data or command byte |
| rd | input | 1 | Read strobe; rdata loads on the next edge |
| rdata | output | DW | Registered read data or program status |
| accel | input | 1 | Accelerate request, forces bypass mode |
| ready | output | 1 | High when no embedded program is running |

## Verification
The hardest situation to reach is a hardware reset in the middle of a bypass-mode program. It needs bypass entry, a two-write program, and a reset in a window only PROG_CYCLES long. The stimulus drives that sequence back to back and drops rst_n two cycles into the busy window. It then tries a lone A0h program: bypass mode must have been cleared, so this must do nothing, and the target word must keep its erased value. A second hard case is the interaction of the secured overlay with bypass. The bench enters the overlay first, then issues the 20h command and an accelerate pulse, and shows at the ports that neither starts a program.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_PDATA,
        S_BUSY,
        S_BYP,
        S_BDATA,
        S_BRST,
        S_SEXIT
    } seq_state_t;

    localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
    localparam logic [7:0]  CMD_UNLK_B = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'hA0;
    localparam logic [7:0]  CMD_BYPASS = 8'h20;
    localparam logic [7:0]  CMD_SECIN  = 8'h88;
    localparam logic [7:0]  CMD_EXIT   = 8'h90;
    localparam logic [7:0]  CMD_ZERO   = 8'h00;
    localparam logic [10:0] ADR_KEY1   = 11'h555;
    localparam logic [10:0] ADR_KEY2   = 11'h2AA;

endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int PROG_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(PROG_CYCLES - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = running && (cnt == '0);

endmodule

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import flash_cmd_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          accel,
    input  logic          done,
    output logic          start,
    output logic          commit,
    output logic          busy,
    output logic          sec_mode,
    output logic          byp_mode,
    output logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    seq_state_t state, state_n;
    logic       sec_n, byp_n;
    logic       accel_go;
    logic [7:0] cmd;
    logic       at_key1, at_key2;

    assign cmd     = wdata[7:0];
    assign at_key1 = (addr[10:0] == ADR_KEY1);
    assign at_key2 = (addr[10:0] == ADR_KEY2);

    assign accel_go = accel && !sec_mode && !byp_mode && (state != S_BUSY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sec_mode <= 1'b0;
            byp_mode <= 1'b0;
        end else begin
            state    <= state_n;
            sec_mode <= sec_n;
            byp_mode <= byp_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        sec_n   = sec_mode;
        byp_n   = byp_mode;
        if (accel_go) begin
            state_n = S_BYP;
            byp_n   = 1'b1;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (we && cmd == CMD_UNLK_A && at_key1) state_n = S_UNLK1;
                end
                S_UNLK1: begin
                    if (we) state_n = (cmd == CMD_UNLK_B && at_key2) ? S_UNLK2 : S_IDLE;
                end
                S_UNLK2: begin
                    if (we) begin
                        state_n = S_IDLE;
                        if (at_key1) begin
                            if (cmd == CMD_SETUP) begin
                                state_n = S_PDATA;
                            end else if (cmd == CMD_BYPASS && !sec_mode) begin
                                state_n = S_BYP;
                                byp_n   = 1'b1;
                            end else if (cmd == CMD_SECIN && !sec_mode) begin
                                sec_n = 1'b1;
                            end else if (cmd == CMD_EXIT && sec_mode) begin
                                state_n = S_SEXIT;
                            end
                        end
                    end
                end
                S_PDATA, S_BDATA: begin
                    if (we) state_n = S_BUSY;
                end
                S_BUSY: begin
                    if (done) state_n = byp_mode ? S_BYP : S_IDLE;
                end
                S_BYP: begin
                    if (we && cmd == CMD_SETUP)     state_n = S_BDATA;
                    else if (we && cmd == CMD_EXIT) state_n = S_BRST;
                end
                S_BRST: begin
                    if (we) begin
                        if (cmd == CMD_ZERO) begin
                            state_n = S_IDLE;
                            byp_n   = 1'b0;
                        end else begin
                            state_n = S_BYP;
                        end
                    end
                end
                S_SEXIT: begin
                    if (we) begin
                        state_n = S_IDLE;
                        if (cmd == CMD_ZERO) sec_n = 1'b0;
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        busy   = (state == S_BUSY);
        commit = busy && done;
        start  = we && !accel_go && (state == S_PDATA || state == S_BDATA);
    end

    // Latched program target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr <= '0;
            pdata <= '0;
        end else if (start) begin
            paddr <= addr;
            pdata <= wdata;
        end
    end

endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
    parameter int AW  = 11,
    parameter int DW  = 8,
    parameter int SAW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          sec_sel,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pdata,
    input  logic          rd,
    input  logic [AW-1:0] raddr,
    input  logic          busy,
    output logic          fail,
    output logic [DW-1:0] rdata
);
    localparam int MAIN_WORDS = 1 << AW;
    localparam int SEC_WORDS  = 1 << SAW;

    logic [DW-1:0] mem  [MAIN_WORDS];
    logic [DW-1:0] smem [SEC_WORDS];
    logic [DW-1:0] target;
    logic [DW-1:0] status;
    logic          tog;

    initial begin
        for (int i = 0; i < MAIN_WORDS; i++) mem[i] = '1;
        for (int j = 0; j < SEC_WORDS; j++)  smem[j] = '1;
    end

    assign target = sec_sel ? smem[paddr[SAW-1:0]] : mem[paddr];
    assign fail   = |(pdata & ~target);

    always_comb begin
        status    = '0;
        status[7] = ~pdata[7];
        status[6] = ~tog;
        status[5] = fail;
    end

    // Program only clears bits
    always_ff @(posedge clk) begin
        if (commit) begin
            if (sec_sel) smem[paddr[SAW-1:0]] <= smem[paddr[SAW-1:0]] & pdata;
            else         mem[paddr]           <= mem[paddr] & pdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else if (rd) begin
            if (busy) begin
                tog   <= ~tog;
                rdata <= status;
            end else if (sec_sel) begin
                rdata <= smem[raddr[SAW-1:0]];
            end else begin
                rdata <= mem[raddr];
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int AW          = 11,
    parameter int DW          = 8,
    parameter int SAW         = 4,
    parameter int PROG_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    input  logic          accel,
    output logic          ready
);
    logic          start, commit, busy, done, fail;
    logic          sec_mode, byp_mode;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pdata;

    fcs_decoder #(.AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .accel(accel), .done(done), .start(start), .commit(commit),
        .busy(busy), .sec_mode(sec_mode), .byp_mode(byp_mode),
        .paddr(paddr), .pdata(pdata)
    );

    fcs_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done)
    );

    fcs_array #(.AW(AW), .DW(DW), .SAW(SAW)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .sec_sel(sec_mode),
        .paddr(paddr), .pdata(pdata), .rd(rd), .raddr(addr), .busy(busy),
        .fail(fail), .rdata(rdata)
    );

    assign ready = !busy;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int DW          = 8,
    parameter int PROG_CYCLES = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          we,
    input logic          rd,
    input logic          accel,
    input logic          ready,
    input logic [DW-1:0] rdata,
    input logic          sec_mode,
    input logic          byp_mode
);
    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len <= 0;
        else if (!ready) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    p_start_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(we));

    p_busy_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (busy_len < PROG_CYCLES));

    p_busy_full_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_len == PROG_CYCLES));

    p_modes_frozen_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(sec_mode) && $stable(byp_mode)));

    p_accel_enters_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accel && ready && !sec_mode && !byp_mode) |=> byp_mode);

    p_modes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_mode && byp_mode));

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

bind flash_cmd_seq fcs_checker #(.DW(DW), .PROG_CYCLES(PROG_CYCLES)) i_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .rd(rd), .accel(accel), .ready(ready),
    .rdata(rdata), .sec_mode(sec_mode), .byp_mode(byp_mode)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11, DW = 8, SAW = 4, CYC = 8;

    localparam logic [2:0] K_PROG = 3'd0, K_RD = 3'd1, K_WR = 3'd2, K_RDY = 3'd3;

    typedef struct packed {
        logic [2:0]  kind;
        logic [10:0] a;
        logic [7:0]  d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{K_PROG, 11'h010, 8'h5A, 4'd1},   // R1
        '{K_RD,   11'h010, 8'h5A, 4'd1},   // R1
        '{K_PROG, 11'h010, 8'h0F, 4'd4},   // R4
        '{K_RD,   11'h010, 8'h0A, 4'd4},   // R4
        '{K_PROG, 11'h7FF, 8'h00, 4'd1},   // R1 top word
        '{K_RD,   11'h7FF, 8'h00, 4'd1},
        '{K_PROG, 11'h000, 8'hA5, 4'd1},   // R1 bottom word
        '{K_RD,   11'h000, 8'hA5, 4'd1},
        '{K_RD,   11'h011, 8'hFF, 4'd1},
        '{K_WR,   11'h555, 8'hAA, 4'd8},   // R8 broken unlock
        '{K_WR,   11'h2AA, 8'h54, 4'd8},
        '{K_WR,   11'h555, 8'hA0, 4'd8},
        '{K_WR,   11'h020, 8'h00, 4'd8},
        '{K_RDY,  11'h000, 8'h01, 4'd8},
        '{K_RD,   11'h020, 8'hFF, 4'd8},
        '{K_WR,   11'h555, 8'hF0, 4'd8}    // R8 reset command
    };

    logic          clk = 1'b0, rst_n = 1'b0, we = 1'b0, rd = 1'b0, accel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ready;

    int  n_chk = 0, n_err = 0;
    bit  done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW), .SAW(SAW), .PROG_CYCLES(CYC)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rd(rd), .rdata(rdata), .accel(accel), .ready(ready)
    );

    task automatic chk(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_get(input logic [10:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        rd = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input logic [10:0] a, input logic [7:0] exp, input int req);
        logic [DW-1:0] v;
        rd_get(a, v);
        chk(v == exp, req, 32'(v), 32'(exp), $sformatf("read %0h", a));
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic prog_std(input logic [10:0] a, input logic [7:0] d, input int req);
        int n;
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
        chk(ready == 1'b0, 1, 32'(ready), 0, "ready low after data write");   // R1
        wait_ready(n);
        chk(n == CYC, 2, 32'(n), 32'(CYC), "busy length");                    // R2
    endtask

    task automatic prog_byp(input logic [10:0] a, input logic [7:0] d, input bit wt);
        int n;
        wr(a, 8'hA0); wr(a, d);
        if (wt) begin
            chk(ready == 1'b0, 5, 32'(ready), 0, "bypass program started");  // R5
            wait_ready(n);
        end
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] s1, s2;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, 12, 32'(ready), 1, "ready after reset");   // R12
        chk(rdata == '0, 13, 32'(rdata), 0, "rdata after reset");     // R13
        rd_chk(11'h000, 8'hFF, 1);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].kind)
                K_PROG: prog_std(VECS[i].a, VECS[i].d, int'(VECS[i].req));
                K_RD:   rd_chk(VECS[i].a, VECS[i].d, int'(VECS[i].req));
                K_WR:   wr(VECS[i].a, VECS[i].d);
                default: chk(ready == VECS[i].d[0], int'(VECS[i].req), 32'(ready),
                             32'(VECS[i].d[0]), "ready level");
            endcase
        end
        prog_std(11'h021, 8'h3C, 8);                 // R8 still works after F0
        rd_chk(11'h021, 8'h3C, 8);

        // R2: writes during busy are ignored
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h030, 8'hF0);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
        wait_ready(n);
        wr(11'h031, 8'h00);
        chk(ready == 1'b1, 2, 32'(ready), 1, "no program from busy-time writes");
        rd_chk(11'h031, 8'hFF, 2);
        rd_chk(11'h030, 8'hF0, 2);

        // R3: status reads
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h040, 8'h00);
        rd_get(11'h040, s1); rd_get(11'h040, s2);
        chk(s1[7] == 1'b1, 3, 32'(s1), 32'h80, "status bit7 complement");
        chk(s1[6] != s2[6], 3, 32'(s2), 32'(s1 ^ 8'h40), "status bit6 toggles");
        chk(s1[5] == 1'b0 && s1[4:0] == 5'd0, 3, 32'(s1), 32'(s1 & 8'hC0), "status no fail");
        wait_ready(n);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h040, 8'h80);
        rd_get(11'h040, s1);
        chk(s1[7] == 1'b0 && s1[5] == 1'b1, 3, 32'(s1), 32'(8'h20 | (s1 & 8'h40)), "status fail flag");
        wait_ready(n);
        rd_chk(11'h040, 8'h00, 4);                   // R4 bit stays cleared

        // R5: bypass entry and programs
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20);
        prog_byp(11'h050, 8'h77, 1);
        rd_chk(11'h050, 8'h77, 5);
        prog_byp(11'h051, 8'h11, 1);
        rd_chk(11'h051, 8'h11, 5);
        // R6: other writes ignored in bypass
        wr(11'h555, 8'hAA); wr(11'h052, 8'h00);
        chk(ready == 1'b1, 6, 32'(ready), 1, "ignored bypass write");
        rd_chk(11'h052, 8'hFF, 6);
        prog_byp(11'h053, 8'h22, 1);
        rd_chk(11'h053, 8'h22, 6);
        // R7: bypass reset
        wr(11'h000, 8'h90); wr(11'h000, 8'h00);
        wr(11'h054, 8'hA0); wr(11'h054, 8'h00);
        chk(ready == 1'b1, 7, 32'(ready), 1, "lone A0 after bypass reset");
        rd_chk(11'h054, 8'hFF, 7);

        // R9: accelerate into bypass
        @(negedge clk); accel = 1'b1;
        @(negedge clk); accel = 1'b0;
        prog_byp(11'h060, 8'h44, 1);
        rd_chk(11'h060, 8'h44, 9);
        wr(11'h000, 8'h90); wr(11'h000, 8'h00);

        // R10: secured overlay
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h88);
        rd_chk(11'h000, 8'hFF, 10);
        prog_std(11'h002, 8'h12, 10);
        rd_chk(11'h002, 8'h12, 10);
        rd_chk(11'h012, 8'h12, 10);
        // R11: no bypass while secured
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20);
        wr(11'h005, 8'hA0); wr(11'h005, 8'h00);
        chk(ready == 1'b1, 11, 32'(ready), 1, "20h ignored while secured");
        rd_chk(11'h005, 8'hFF, 11);
        @(negedge clk); accel = 1'b1;
        @(negedge clk); accel = 1'b0;
        wr(11'h006, 8'hA0); wr(11'h006, 8'h00);
        chk(ready == 1'b1, 11, 32'(ready), 1, "accel ignored while secured");
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90); wr(11'h000, 8'h00);
        rd_chk(11'h000, 8'hA5, 10);
        rd_chk(11'h002, 8'hFF, 10);

        // R13: rdata holds without rd
        @(negedge clk); addr = AW'(11'h070);
        repeat (3) @(negedge clk);
        chk(rdata == 8'hFF, 13, 32'(rdata), 32'hFF, "rdata hold");
        rd_chk(11'h7FF, 8'h00, 13);
        @(negedge clk); addr = AW'(11'h000);
        repeat (2) @(negedge clk);
        chk(rdata == 8'h00, 13, 32'(rdata), 0, "rdata hold after change");

        // R12: reset aborts bypass program
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20);
        prog_byp(11'h070, 8'h00, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, 12, 32'(ready), 1, "ready after abort");
        rd_chk(11'h070, 8'hFF, 12);
        wr(11'h072, 8'hA0); wr(11'h072, 8'h00);
        chk(ready == 1'b1, 12, 32'(ready), 1, "bypass cleared by reset");
        rd_chk(11'h072, 8'hFF, 12);

        finish_run();
    end

endmodule